// File: doc/BRIEF.md
# Deferred Transmit Reset Controller

This block sits between the transmit data FIFO of a packet bridge and the framed outgoing link. Software asks for a transmit-side reset by writing a key value to a dedicated write-only offset. The request does not take effect at once. The block follows start-of-frame and end-of-frame on the link. It waits until no frame is partly sent. Only then does it pulse a reset that goes to the transmit FIFO and the transmit framing logic alone. The far end never receives a cut-short frame.

While a request is waiting and the link sits between frames, the block closes the handshake in both directions so that no new frame can begin. Beats that belong to a frame already under way still pass, so the link always drains. When the pulse ends, a completion flag is raised. That flag drives an interrupt output through an enable bit, and the enable bit comes out of reset set.

Top module: `tx_reset_guard`

## Requirements
- R1: Reads return the completion flag in bit 0 at offset 0 and the interrupt enable in bit 0 at offset 1. Reads of the reset-key offset 2, and of any other offset, return zero.
- R2: A write of exactly 0x000000A5 to offset 2 requests the transmit reset. A write of any other value to offset 2, or of 0xA5 to any other offset, starts nothing.
- R3: A frame is in flight from an accepted beat that carries start-of-frame without end-of-frame until the accepted beat that carries end-of-frame. A beat is accepted when `up_src_rdy` and `dn_dst_rdy` are both high and the gate is open. `tx_rst` is never high while a frame is in flight.
- R4: Once a request is waiting and no frame is in flight, `tx_rst` goes high on the next cycle. It stays high for exactly 4 consecutive cycles.
- R5: From the moment a request is accepted until the controller returns to idle, the gate is closed whenever no frame is in flight: `up_dst_rdy` and `dn_src_rdy` are both held low. At all other times `up_dst_rdy` follows `dn_dst_rdy` and `dn_src_rdy` follows `up_src_rdy`.
- R6: A key write made while a request is waiting, or while the reset is running or completing, merges with that request. It produces no second pulse.
- R7: The completion flag is set on the second cycle after `tx_rst` falls. Writing 1 to bit 0 of offset 0 clears it, and writing 0 leaves it unchanged. If a set and a clear fall on the same cycle, the set wins.
- R8: `irq` is high exactly when the completion flag and the enable bit are both 1. The enable bit is written through bit 0 of offset 1.
- R9: After reset, `tx_rst` is low, the completion flag is 0, the enable bit is 1, `irq` is low and the gate is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register write offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 4 | Register read offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| up_src_rdy | input | 1 | FIFO side has a beat to send |
| up_sof | input | 1 | Current beat starts a frame |
| up_eof | input | 1 | Current beat ends a frame |
| up_dst_rdy | output | 1 | Gated ready returned to the FIFO |
| dn_src_rdy | output | 1 | Gated valid presented to the link |
| dn_dst_rdy | input | 1 | Far end ready |
| tx_rst | output | 1 | Reset pulse for transmit FIFO and framing |
| irq | output | 1 | Masked completion interrupt |

## Verification
The assertions assume well-formed framing from the FIFO side. Start-of-frame marks only the first beat of a frame, end-of-frame marks only the last, and a beat and its flags stay in place until the beat is accepted. The stimulus keeps to this with a frame generator. The generator draws a random length of one to six beats, raises start-of-frame only at position zero and end-of-frame only at the last position, and advances only when it sees its beat accepted. Register writes are random in offset, value and timing, and key writes often land in the middle of frames and during a running reset, so the merge and deferral paths are exercised.

// File: rtl/txr_pkg.sv
// Package: shared types for the deferred transmit reset controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package txr_pkg;

    // Controller phases, in the order they are visited.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PENDING   = 2'd1,
        ST_RESETTING = 2'd2,
        ST_DONE      = 2'd3
    } txr_state_e;

endpackage : txr_pkg

// File: rtl/txr_regs.sv
// Module: txr_regs
// Register front end. It decodes the key write into a one-cycle request,
// keeps the completion flag (write-1-to-clear, set has priority) and the
// interrupt enable (resets to 1), and drives the combinational read mux.
// Assumes one write per cycle and that done_evt comes from the sequencer.
module txr_regs #(
    parameter int          ADDR_W      = 4,
    parameter int          DATA_W      = 32,
    parameter int unsigned KEY_VALUE   = 32'hA5,
    parameter int          ADDR_STATUS = 0,
    parameter int          ADDR_ENABLE = 1,
    parameter int          ADDR_KEY    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              done_evt,
    output logic              req_strobe,
    output logic              flag_q,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(ADDR_ENABLE);
    localparam logic [ADDR_W-1:0] A_KEY    = ADDR_W'(ADDR_KEY);
    localparam logic [DATA_W-1:0] KEY      = DATA_W'(KEY_VALUE);

    logic en_q;
    logic wr_status;
    logic wr_enable;

    // Decode the three write targets.
    always_comb begin
        req_strobe = wr_en && (wr_addr == A_KEY) && (wr_data == KEY);
        wr_status  = wr_en && (wr_addr == A_STATUS);
        wr_enable  = wr_en && (wr_addr == A_ENABLE);
    end

    // Completion flag: set on done, cleared by writing 1, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (done_evt) begin
            flag_q <= 1'b1;
        end else if (wr_status && wr_data[0]) begin
            flag_q <= 1'b0;
        end
    end

    // Interrupt enable: comes out of reset unmasked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b1;
        end else if (wr_enable) begin
            en_q <= wr_data[0];
        end
    end

    // Masked interrupt output.
    always_comb irq = flag_q & en_q;

    // Read mux; the key offset is not storage and reads as zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_STATUS) begin
            rd_data[0] = flag_q;
        end else if (rd_addr == A_ENABLE) begin
            rd_data[0] = en_q;
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> flag_q); // R7

endmodule : txr_regs

// File: rtl/txr_link_gate.sv
// Module: txr_link_gate
// Tracks whether a frame is in flight on the transmit link and closes the
// ready/valid handshake between frames while a reset is being held off.
// Assumes well-formed framing: sof only on a first beat, eof only on a last.
module txr_link_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic up_src_rdy,
    input  logic up_sof,
    input  logic up_eof,
    output logic up_dst_rdy,
    output logic dn_src_rdy,
    input  logic dn_dst_rdy,
    output logic busy
);

    logic gate_closed;
    logic beat_ok;

    // Close the gate only between frames while a reset is outstanding.
    always_comb begin
        gate_closed = hold_req && !busy;
        up_dst_rdy  = dn_dst_rdy & ~gate_closed;
        dn_src_rdy  = up_src_rdy & ~gate_closed;
        beat_ok     = up_src_rdy & dn_dst_rdy & ~gate_closed;
    end

    // In-flight tracker: opens on sof without eof, closes on eof.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (beat_ok) begin
            if (up_eof) begin
                busy <= 1'b0;
            end else if (up_sof) begin
                busy <= 1'b1;
            end
        end
    end

endmodule : txr_link_gate

// File: rtl/txr_sequencer.sv
// Module: txr_sequencer
// Deferral state machine: IDLE -> PENDING -> RESETTING -> DONE -> IDLE.
// Holds a request until the link has no frame in flight, then drives the
// transmit reset for RST_CYCLES cycles and signals completion for one cycle.
// Requests arriving outside IDLE merge into the current one.
module txr_sequencer
    import txr_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic busy,
    output logic hold,
    output logic tx_rst,
    output logic done_evt
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

    txr_state_e        state_q;
    txr_state_e        state_d;
    logic [CNT_W-1:0]  cnt_q;

    // Next-state logic for the deferral sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req) state_d = ST_PENDING;
            ST_PENDING:   if (!busy) state_d = ST_RESETTING;
            ST_RESETTING: if (cnt_q == CNT_LAST) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Pulse-length counter, cleared outside the reset phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_RESETTING) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // Decode outputs from the state.
    always_comb begin
        hold     = (state_q != ST_IDLE);
        tx_rst   = (state_q == ST_RESETTING);
        done_evt = (state_q == ST_DONE);
    end

    AST_RST_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |-> !busy); // R3
    AST_REQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req && state_q == ST_IDLE) |=> (state_q == ST_PENDING)); // R2

endmodule : txr_sequencer

// File: rtl/tx_reset_guard.sv
// Module: tx_reset_guard
// Top of the deferred transmit reset controller. It joins the register
// front end, the link gate and the sequencer. tx_rst drives transmit logic
// only. Assumes a single clock and a synchronous active-low reset.
module tx_reset_guard #(
    parameter int          ADDR_W      = 4,
    parameter int          DATA_W      = 32,
    parameter int unsigned KEY_VALUE   = 32'hA5,
    parameter int          ADDR_STATUS = 0,
    parameter int          ADDR_ENABLE = 1,
    parameter int          ADDR_KEY    = 2,
    parameter int          RST_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [ADDR_W-1:0] reg_rd_addr,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              up_src_rdy,
    input  logic              up_sof,
    input  logic              up_eof,
    output logic              up_dst_rdy,
    output logic              dn_src_rdy,
    input  logic              dn_dst_rdy,
    output logic              tx_rst,
    output logic              irq
);

    localparam int RUN_W = $clog2(RST_CYCLES + 1) + 1;

    logic req_strobe;
    logic done_evt;
    logic hold;
    logic busy;
    logic flag_q;

    txr_regs #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .KEY_VALUE   (KEY_VALUE),
        .ADDR_STATUS (ADDR_STATUS),
        .ADDR_ENABLE (ADDR_ENABLE),
        .ADDR_KEY    (ADDR_KEY)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_addr    (reg_wr_addr),
        .wr_data    (reg_wr_data),
        .rd_addr    (reg_rd_addr),
        .rd_data    (reg_rd_data),
        .done_evt   (done_evt),
        .req_strobe (req_strobe),
        .flag_q     (flag_q),
        .irq        (irq)
    );

    txr_link_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_req   (hold),
        .up_src_rdy (up_src_rdy),
        .up_sof     (up_sof),
        .up_eof     (up_eof),
        .up_dst_rdy (up_dst_rdy),
        .dn_src_rdy (dn_src_rdy),
        .dn_dst_rdy (dn_dst_rdy),
        .busy       (busy)
    );

    txr_sequencer #(
        .RST_CYCLES (RST_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_strobe),
        .busy     (busy),
        .hold     (hold),
        .tx_rst   (tx_rst),
        .done_evt (done_evt)
    );

    // Checker counter: length of the current tx_rst run.
    logic [RUN_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (tx_rst) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    AST_RST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_rst) |-> (run_len == RUN_W'(RST_CYCLES))); // R4
    AST_NO_BEAT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |-> (!dn_src_rdy && !up_dst_rdy)); // R5
    AST_FLAG_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_rst) |=> flag_q); // R7

endmodule : tx_reset_guard

// File: tb/test_tx_reset_guard.sv
// Bench for tx_reset_guard: a seeded random frame generator and random
// register traffic, plus directed corner cases, checked each cycle against
// an expected-value model built from the requirements.
module test_tx_reset_guard;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] KEY = 32'h0000_00A5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [3:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        up_src_rdy = 1'b0;
    logic        up_sof = 1'b0;
    logic        up_eof = 1'b0;
    logic        up_dst_rdy;
    logic        dn_src_rdy;
    logic        dn_dst_rdy = 1'b0;
    logic        tx_rst;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // Expected-value model state.
    int m_state = 0;   // 0 idle, 1 waiting, 2 resetting, 3 completing
    int m_cnt = 0;
    bit m_busy = 0;
    bit m_flag = 0;
    bit m_en = 1;
    int pulses = 0;

    // Frame generator state.
    int  g_pos = 0;
    int  g_len = 1;
    bit  g_on = 0;
    bit  g_random = 1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tx_reset_guard i_tx_reset_guard (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .up_src_rdy(up_src_rdy), .up_sof(up_sof), .up_eof(up_eof),
        .up_dst_rdy(up_dst_rdy), .dn_src_rdy(dn_src_rdy), .dn_dst_rdy(dn_dst_rdy),
        .tx_rst(tx_rst), .irq(irq)
    );

    function automatic bit f_gate_closed();
        return (m_state != 0) && !m_busy;
    endfunction

    function automatic logic [31:0] f_rd(input logic [3:0] a);
        if (a == 4'd0) return {31'b0, m_flag};
        if (a == 4'd1) return {31'b0, m_en};
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, check mid-cycle, update the model at posedge.
    task automatic step(input bit we, input logic [3:0] wa, input logic [31:0] wd,
                        input string rst_tag);
        bit acc;
        bit key;
        @(negedge clk);
        reg_wr_en   = we;
        reg_wr_addr = wa;
        reg_wr_data = wd;
        reg_rd_addr = 4'($urandom_range(0, 4));
        up_sof      = (g_pos == 0);
        up_eof      = (g_pos == g_len - 1);
        up_src_rdy  = g_random ? 1'($urandom_range(0, 3) != 0) : g_on;
        dn_dst_rdy  = g_random ? 1'($urandom_range(0, 3) != 0) : 1'b1;
        #1;
        chk(rst_tag, {31'b0, tx_rst}, {31'b0, (m_state == 2)});
        chk("R5 up_dst_rdy", {31'b0, up_dst_rdy}, {31'b0, dn_dst_rdy & !f_gate_closed()});
        chk("R5 dn_src_rdy", {31'b0, dn_src_rdy}, {31'b0, up_src_rdy & !f_gate_closed()});
        chk("R8 irq", {31'b0, irq}, {31'b0, m_flag & m_en});
        chk("R1 read", reg_rd_data, f_rd(reg_rd_addr));
        if (m_state == 2) begin
            chk("R3 no reset in frame", {31'b0, m_busy}, 32'h0);
        end
        acc = up_src_rdy && dn_dst_rdy && !f_gate_closed();
        key = we && (wa == 4'd2) && (wd == KEY);
        @(posedge clk);
        // Model update from the requirements.
        if (acc) begin
            if (up_eof) m_busy = 0;
            else if (up_sof) m_busy = 1;
            if (up_eof) begin
                g_pos = 0;
                g_len = $urandom_range(1, 6);
            end else begin
                g_pos++;
            end
        end
        if (m_state == 3) m_flag = 1;
        else if (we && wa == 4'd0 && wd[0]) m_flag = 0;
        if (we && wa == 4'd1) m_en = wd[0];
        case (m_state)
            0: if (key) m_state = 1;
            1: if (!m_busy_prev(acc, up_sof, up_eof)) begin m_state = 2; m_cnt = 0; end
            2: begin
                if (m_cnt == 3) begin m_state = 3; pulses++; end
                else m_cnt++;
            end
            default: m_state = 0;
        endcase
    endtask

    // The waiting phase leaves on the cycle after the link has no frame in
    // flight; that decision uses the in-flight value from before this edge.
    bit busy_before;
    function automatic bit m_busy_prev(input bit acc, input bit sof, input bit eof);
        return busy_before;
    endfunction

    task automatic idle_cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            busy_before = m_busy;
            step(1'b0, 4'd0, 32'h0, tag);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        busy_before = m_busy;
        step(1'b1, a, d, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int p0;
        void'($urandom(32'h5EED_0042));
        g_len = 3;
        repeat (3) @(posedge clk);
        // R9: reset state, inputs quiet.
        @(negedge clk);
        chk("R9 tx_rst", {31'b0, tx_rst}, 32'h0);
        chk("R9 irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        up_src_rdy = 1'b0;
        dn_dst_rdy = 1'b1;
        reg_rd_addr = 4'd1;
        #1;
        chk("R9 enable", reg_rd_data, 32'h1);
        reg_rd_addr = 4'd0;
        #1;
        chk("R9 flag", reg_rd_data, 32'h0);
        chk("R9 gate open", {31'b0, up_dst_rdy}, 32'h1);

        // R2: wrong value, wrong offset: no pulse.
        g_random = 0; g_on = 0;
        p0 = pulses;
        wr(4'd2, 32'h0000_00A4, "R2 wrong value");
        wr(4'd2, 32'h0000_01A5, "R2 wrong value");
        wr(4'd3, KEY, "R2 wrong offset");
        idle_cycles(10, "R2 no reset");
        chk("R2 no pulse", pulses, p0);

        // R3/R4: key mid-frame; reset waits until eof accepted.
        g_on = 1; g_pos = 0; g_len = 6;
        idle_cycles(2, "R3 frame");
        wr(4'd2, KEY, "R3 key mid frame");
        idle_cycles(12, "R4 deferred pulse");
        // R6: key during the pulse merges.
        g_on = 0;
        p0 = pulses;
        wr(4'd2, KEY, "R4");
        idle_cycles(2, "R4");
        wr(4'd2, KEY, "R6 merged key");
        idle_cycles(8, "R6 single pulse");
        chk("R6 one pulse", pulses, p0 + 1);

        // R7: flag set, write 0 keeps it, write 1 clears it.
        wr(4'd0, 32'h0, "R7");
        idle_cycles(1, "R7");
        reg_rd_addr = 4'd0;
        chk("R7 flag kept", {31'b0, m_flag}, 32'h1);
        wr(4'd0, 32'h1, "R7 clear");
        idle_cycles(1, "R7");
        // R8: mask then re-enable.
        wr(4'd1, 32'h0, "R8 mask");
        wr(4'd2, KEY, "R8");
        idle_cycles(10, "R8 masked");
        wr(4'd1, 32'h1, "R8 unmask");
        idle_cycles(2, "R8");

        // Random phase: frames and register traffic.
        g_random = 1;
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 15);
            busy_before = m_busy;
            if (r < 2) begin
                step(1'b1, 4'd2, ($urandom_range(0, 3) != 0) ? KEY : $urandom, "R4 random");
            end else if (r == 2) begin
                step(1'b1, 4'($urandom_range(0, 3)), 32'($urandom_range(0, 1)), "R4 random");
            end else begin
                step(1'b0, 4'd0, 32'h0, "R4 random");
            end
        end
        chk("R4 pulses seen", {31'b0, pulses > 20}, 32'h1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule : test_tx_reset_guard